// File: doc/BRIEF.md
# Three-wire serial control register file

This block is the control-register slave of a scanner front end. An external controller reaches it over three wires: a serial clock, a frame strobe and one data line whose direction turns around during reads. Behind the link sit eight 9-bit registers: a configuration word, a channel-order and timing-delay word, three gain words and three offset words. The fields of these registers drive the block's output ports without further processing. Gains leave as raw 6-bit codes. Offsets leave as 9-bit sign-magnitude words.

All three link inputs are treated as asynchronous. Each passes through a synchronizer clocked by the system clock, and the block finds the edges by comparing successive samples. A frame opens when the strobe rises and closes when it falls. The link controller has four states. `ST_IDLE` goes to `ST_HDR` when the strobe rises. `ST_HDR` collects the direction bit and the address, then goes to `ST_WDATA` or `ST_RDATA` on the fourth rising serial-clock edge, as the direction bit selects. Any state returns to `ST_IDLE` when the strobe falls, and this can happen partway through a frame. On a fall out of `ST_WDATA`, the write takes effect only if exactly thirteen clock edges were counted. On the pad, the external tri-state buffer combines the data-out and drive-enable ports with the data-in port.

Top module: `serial_ctl_regs`

## Requirements
- R1: After reset, address 0 reads 0x078, address 1 reads 0x0C8, and addresses 2 to 7 read 0.
- R2: A frame carries a direction bit (1 = read, 0 = write), then a 3-bit address MSB first, then 9 data bits MSB first. Bits are sampled on rising serial-clock edges while the strobe is high. Address 0 is configuration and 1 is channel order. Addresses 2, 3 and 4 are the red, green and blue gains. Addresses 5, 6 and 7 are the red, green and blue offsets.
- R3: A write changes a register only if exactly 13 rising serial-clock edges are counted before the strobe falls. A write frame of any other length leaves every register unchanged.
- R4: In a read frame, the addressed register appears on the data-out port, d8 first. The port takes a new bit on each falling serial-clock edge, starting with the fall that follows the fourth rising edge.
- R5: Drive-enable is high only from that first data-phase falling edge until the strobe falls. It is never high during a write frame or between frames.
- R6: A gain register keeps only d5..d0. Its bits d8..d6 always read 0, and its gain port shows d5..d0 unchanged.
- R7: An offset port shows the whole 9-bit register, with d8 as the sign and d7..d0 as the magnitude.
- R8: Configuration bit mapping: d5 selects three-channel mode, d4 enables correlated double sampling, d3 selects high clamp bias, d2 requests power-down, d1 enables output delay, and d0 selects single-byte output.
- R9: Channel-order bit mapping: d7 selects red-first order, d6 selects red, d5 selects green, d4 selects blue, d3 enables the delays, d2 sets the reference-sample delay, d1 sets the data-sample delay, and d0 sets the converter-clock delay.
- R10: Writing the power-down bit leaves every other register unchanged, and later frames still read and write normally.
- R11: If the strobe falls in the same synchronized cycle as a rising serial-clock edge, the strobe fall takes priority and that clock edge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock (asynchronous) |
| ser_frame | input | 1 | Frame strobe, high during a transfer |
| ser_din | input | 1 | Data line, input side |
| ser_dout | output | 1 | Data line, output side |
| ser_doe | output | 1 | Data line drive enable |
| cfg_three_ch | output | 1 | Three-channel mode |
| cfg_cds_on | output | 1 | Correlated double sampling on |
| cfg_clamp_hi | output | 1 | High clamp bias |
| cfg_pwr_down | output | 1 | Power-down request |
| cfg_out_dly | output | 1 | Output delay on |
| cfg_byte_only | output | 1 | Single-byte output |
| ord_rgb_first | output | 1 | Red-first channel order |
| sel_red | output | 1 | Red channel selected |
| sel_green | output | 1 | Green channel selected |
| sel_blue | output | 1 | Blue channel selected |
| dly_enable | output | 1 | Internal delays enabled |
| dly_cds_ref | output | 1 | Reference-sample delay code |
| dly_cds_dat | output | 1 | Data-sample delay code |
| dly_adc | output | 1 | Converter-clock delay code |
| gain_red | output | 6 | Red gain code |
| gain_green | output | 6 | Green gain code |
| gain_blue | output | 6 | Blue gain code |
| ofs_red | output | 9 | Red offset, sign-magnitude |
| ofs_green | output | 9 | Green offset, sign-magnitude |
| ofs_blue | output | 9 | Blue offset, sign-magnitude |

## Verification
Two events can coincide in one synchronized cycle: the strobe falling, which ends the frame and may commit a write, and the thirteenth rising clock edge, which would complete the frame. The bench raises the serial clock and drops the strobe at the same instant on the last bit of a write. It then reads the target register back and expects the old value, because the frame ended with only twelve counted edges. Complete-frame writes and reads sweep every address with several data patterns. The bench computes the expected port values bit by bit from its own model of the registers.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 9;
    localparam int NUM_REGS   = 1 << ADDR_W;
    localparam int HDR_BITS   = 1 + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;

    localparam logic [ADDR_W-1:0] A_CFG    = 3'd0;
    localparam logic [ADDR_W-1:0] A_ORD    = 3'd1;
    localparam logic [ADDR_W-1:0] A_GAIN_R = 3'd2;
    localparam logic [ADDR_W-1:0] A_GAIN_G = 3'd3;
    localparam logic [ADDR_W-1:0] A_GAIN_B = 3'd4;
    localparam logic [ADDR_W-1:0] A_OFS_R  = 3'd5;
    localparam logic [ADDR_W-1:0] A_OFS_G  = 3'd6;
    localparam logic [ADDR_W-1:0] A_OFS_B  = 3'd7;

    // three-channel, sampling on, high clamp, reserved d6 set
    localparam logic [DATA_W-1:0] CFG_DEFAULT = 9'h078;
    // red-first, red selected, delays enabled
    localparam logic [DATA_W-1:0] ORD_DEFAULT = 9'h0C8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_WDATA,
        ST_RDATA
    } link_state_t;

    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        if (idx == int'(A_CFG)) return CFG_DEFAULT;
        if (idx == int'(A_ORD)) return ORD_DEFAULT;
        return '0;
    endfunction

    function automatic logic [DATA_W-1:0] write_mask(input int idx, input int gain_w);
        logic [DATA_W-1:0] m;
        m = '1;
        if (idx >= int'(A_GAIN_R) && idx <= int'(A_GAIN_B)) begin
            for (int b = 0; b < DATA_W; b++) m[b] = (b < gain_w);
        end
        return m;
    endfunction
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= STAGES'({chain, din});
    end

    assign level = chain[STAGES-1];
endmodule

// File: rtl/serreg_link.sv
module serreg_link
    import serreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              frm,
    input  logic              sdi,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_en
);
    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    link_state_t state, state_nx;
    logic [CNT_W-1:0]    cnt;
    logic [HDR_BITS-1:0] hdr;
    logic [HDR_BITS-1:0] hdr_next;
    logic [DATA_W-1:0]   dat;
    logic [DATA_W-1:0]   rd_sh;
    logic sck_q, frm_q;
    logic sck_rise, sck_fall, frm_rise, frm_fall, hdr_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            frm_q <= 1'b0;
        end else begin
            sck_q <= sck;
            frm_q <= frm;
        end
    end

    assign sck_rise = sck & ~sck_q;
    assign sck_fall = ~sck & sck_q;
    assign frm_rise = frm & ~frm_q;
    assign frm_fall = ~frm & frm_q;
    assign hdr_next = {hdr[HDR_BITS-2:0], sdi};
    assign rd_addr  = hdr_next[ADDR_W-1:0];
    assign hdr_last = (state == ST_HDR) && sck_rise && !frm_fall && (cnt == CNT_HDR);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (frm_rise) state_nx = ST_HDR;
            ST_HDR: begin
                if (frm_fall)      state_nx = ST_IDLE;
                else if (hdr_last) state_nx = hdr_next[HDR_BITS-1] ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA: if (frm_fall) state_nx = ST_IDLE;
            ST_RDATA: if (frm_fall) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            hdr     <= '0;
            dat     <= '0;
            rd_sh   <= '0;
            sdo     <= 1'b0;
            sdo_en  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            unique case (state)
                ST_IDLE: if (frm_rise) cnt <= '0;
                ST_HDR, ST_WDATA, ST_RDATA: begin
                    if (frm_fall) begin
                        sdo    <= 1'b0;
                        sdo_en <= 1'b0;
                        if (state == ST_WDATA && cnt == CNT_FULL) begin
                            wr_stb  <= 1'b1;
                            wr_addr <= hdr[ADDR_W-1:0];
                            wr_data <= dat;
                        end
                    end else begin
                        if (sck_rise) begin
                            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                            if (state == ST_HDR)   hdr <= hdr_next;
                            if (state == ST_WDATA) dat <= {dat[DATA_W-2:0], sdi};
                            if (hdr_last)          rd_sh <= rd_data;
                        end
                        if (sck_fall && state == ST_RDATA) begin
                            sdo    <= rd_sh[DATA_W-1];
                            rd_sh  <= {rd_sh[DATA_W-2:0], 1'b0};
                            sdo_en <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R5
    doe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sdo_en);
    // R5
    doe_rdonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en) |-> (state == ST_RDATA));
    // R3
    commit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(cnt) == CNT_FULL));
    // R3
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    // R11
    fall_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_fall && state != ST_IDLE) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank
    import serreg_pkg::*;
#(
    parameter int GAIN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= reset_value(i);
        end else if (wr_stb) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_addr == ADDR_W'(i)) regs[i] <= wr_data & write_mask(i, GAIN_W);
            end
        end
    end

    assign rd_data = regs[rd_addr];

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(regs));
    // R6
    gain_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[A_GAIN_R][DATA_W-1:GAIN_W] == '0) && (regs[A_GAIN_G][DATA_W-1:GAIN_W] == '0)
        && (regs[A_GAIN_B][DATA_W-1:GAIN_W] == '0));
endmodule

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs
    import serreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GAIN_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_frame,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_doe,
    output logic              cfg_three_ch,
    output logic              cfg_cds_on,
    output logic              cfg_clamp_hi,
    output logic              cfg_pwr_down,
    output logic              cfg_out_dly,
    output logic              cfg_byte_only,
    output logic              ord_rgb_first,
    output logic              sel_red,
    output logic              sel_green,
    output logic              sel_blue,
    output logic              dly_enable,
    output logic              dly_cds_ref,
    output logic              dly_cds_dat,
    output logic              dly_adc,
    output logic [GAIN_W-1:0] gain_red,
    output logic [GAIN_W-1:0] gain_green,
    output logic [GAIN_W-1:0] gain_blue,
    output logic [DATA_W-1:0] ofs_red,
    output logic [DATA_W-1:0] ofs_green,
    output logic [DATA_W-1:0] ofs_blue
);
    localparam int N_IN = 3;

    logic [N_IN-1:0] raw_in, lvl;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic wr_stb;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    assign raw_in = {ser_din, ser_frame, ser_clk};

    for (genvar i = 0; i < N_IN; i++) begin : g_sync
        serreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[i]),
            .level (lvl[i])
        );
    end

    serreg_link u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (lvl[0]),
        .frm     (lvl[1]),
        .sdi     (lvl[2]),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sdo     (ser_dout),
        .sdo_en  (ser_doe)
    );

    serreg_bank #(.GAIN_W(GAIN_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .regs    (regs)
    );

    assign cfg_three_ch  = regs[A_CFG][5];
    assign cfg_cds_on    = regs[A_CFG][4];
    assign cfg_clamp_hi  = regs[A_CFG][3];
    assign cfg_pwr_down  = regs[A_CFG][2];
    assign cfg_out_dly   = regs[A_CFG][1];
    assign cfg_byte_only = regs[A_CFG][0];
    assign ord_rgb_first = regs[A_ORD][7];
    assign sel_red       = regs[A_ORD][6];
    assign sel_green     = regs[A_ORD][5];
    assign sel_blue      = regs[A_ORD][4];
    assign dly_enable    = regs[A_ORD][3];
    assign dly_cds_ref   = regs[A_ORD][2];
    assign dly_cds_dat   = regs[A_ORD][1];
    assign dly_adc       = regs[A_ORD][0];
    assign gain_red      = regs[A_GAIN_R][GAIN_W-1:0];
    assign gain_green    = regs[A_GAIN_G][GAIN_W-1:0];
    assign gain_blue     = regs[A_GAIN_B][GAIN_W-1:0];
    assign ofs_red       = regs[A_OFS_R];
    assign ofs_green     = regs[A_OFS_G];
    assign ofs_blue      = regs[A_OFS_B];
endmodule

// File: tb/test_serial_ctl_regs.sv
module test_serial_ctl_regs;
    localparam int HP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_frame = 1'b0, ser_din = 1'b0;
    logic ser_dout, ser_doe;
    logic cfg_three_ch, cfg_cds_on, cfg_clamp_hi, cfg_pwr_down, cfg_out_dly, cfg_byte_only;
    logic ord_rgb_first, sel_red, sel_green, sel_blue, dly_enable, dly_cds_ref, dly_cds_dat, dly_adc;
    logic [5:0] gain_red, gain_green, gain_blue;
    logic [8:0] ofs_red, ofs_green, ofs_blue;

    int total = 0, bad = 0, doe_err = 0;
    bit done = 0;
    logic [8:0] model [8];

    always #4 clk = ~clk;

    serial_ctl_regs i_serial_ctl_regs (
        .clk, .rst_n, .ser_clk, .ser_frame, .ser_din, .ser_dout, .ser_doe,
        .cfg_three_ch, .cfg_cds_on, .cfg_clamp_hi, .cfg_pwr_down, .cfg_out_dly, .cfg_byte_only,
        .ord_rgb_first, .sel_red, .sel_green, .sel_blue, .dly_enable, .dly_cds_ref, .dly_cds_dat,
        .dly_adc, .gain_red, .gain_green, .gain_blue, .ofs_red, .ofs_green, .ofs_blue
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    function automatic logic [63:0] port_vec();
        return {5'b0, cfg_three_ch, cfg_cds_on, cfg_clamp_hi, cfg_pwr_down, cfg_out_dly, cfg_byte_only,
                ord_rgb_first, sel_red, sel_green, sel_blue, dly_enable, dly_cds_ref, dly_cds_dat, dly_adc,
                gain_red, gain_green, gain_blue, ofs_red, ofs_green, ofs_blue};
    endfunction

    function automatic logic [63:0] exp_vec();
        return {5'b0, model[0][5], model[0][4], model[0][3], model[0][2], model[0][1], model[0][0],
                model[1][7], model[1][6], model[1][5], model[1][4],
                model[1][3], model[1][2], model[1][1], model[1][0],
                model[2][5:0], model[3][5:0], model[4][5:0], model[5], model[6], model[7]};
    endfunction

    task automatic send(input logic rw, input logic [2:0] a, input logic [8:0] d,
                        input int nbits, input bit coincide, output logic [8:0] rb);
        logic [12:0] fr;
        fr = {rw, a, d};
        rb = '0;
        ser_frame = 1'b1;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            ser_din = (i < 13) ? fr[12-i] : 1'b0;
            repeat (HP) @(negedge clk);
            if (ser_doe !== (rw && i >= 4)) doe_err++;
            if (rw && i >= 4 && i < 13) rb[12-i] = ser_dout;
            ser_clk = 1'b1;
            if (coincide && i == nbits - 1) ser_frame = 1'b0;
            repeat (HP) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        ser_frame = 1'b0;
        repeat (2 * HP) @(negedge clk);
        if (ser_doe !== 1'b0) doe_err++;
    endtask

    task automatic wr(input logic [2:0] a, input logic [8:0] d);
        logic [8:0] unused_rb;
        send(1'b0, a, d, 13, 1'b0, unused_rb);
        model[a] = (a >= 2 && a <= 4) ? (d & 9'h03F) : d;
    endtask

    task automatic rd_check(input logic [2:0] a, input string req);
        logic [8:0] rb;
        send(1'b1, a, 9'h000, 13, 1'b0, rb);
        check(req, 64'(rb), 64'(model[a]));
    endtask

    initial begin
        logic [8:0] pat [5];
        logic [8:0] rb;
        for (int i = 0; i < 8; i++) model[i] = 9'h000;
        model[0] = 9'h078;
        model[1] = 9'h0C8;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        check("R5 idle doe", 64'(ser_doe), 64'd0);
        check("R1 R8 R9 reset ports", port_vec(), exp_vec());
        for (int a = 0; a < 8; a++) rd_check(3'(a), "R1 R4 reset readback");
        check("R5 doe during reads", 64'(doe_err), 64'd0);

        for (int a = 0; a < 8; a++) begin
            pat[0] = 9'h1FF; pat[1] = 9'h000; pat[2] = 9'h155; pat[3] = 9'h0AA;
            pat[4] = 9'((a * 73 + 29) % 512);
            for (int p = 0; p < 5; p++) begin
                wr(3'(a), pat[p]);
                check("R6 R7 R8 R9 ports after write", port_vec(), exp_vec());
                rd_check(3'(a), "R2 R4 R6 readback");
            end
        end
        check("R5 doe over sweep", 64'(doe_err), 64'd0);

        // R3: short, long and header-only write frames are dropped
        wr(3'd3, 9'h015);
        send(1'b0, 3'd3, 9'h02A, 12, 1'b0, rb);
        rd_check(3'd3, "R3 twelve-bit frame");
        send(1'b0, 3'd3, 9'h02A, 14, 1'b0, rb);
        rd_check(3'd3, "R3 fourteen-bit frame");
        send(1'b0, 3'd3, 9'h02A, 4, 1'b0, rb);
        rd_check(3'd3, "R3 header-only frame");
        check("R3 ports after dropped frames", port_vec(), exp_vec());

        // R10: power-down bit leaves other registers intact
        for (int a = 1; a < 8; a++) wr(3'(a), 9'((a * 51 + 7) % 512));
        wr(3'd0, 9'h07C);
        check("R10 power-down port", 64'(cfg_pwr_down), 64'd1);
        for (int a = 1; a < 8; a++) rd_check(3'(a), "R10 retained");
        wr(3'd6, 9'h1C3);
        rd_check(3'd6, "R10 write while powered down");
        check("R10 ports", port_vec(), exp_vec());

        // R11: strobe fall and last rising edge together
        send(1'b0, 3'd6, 9'h0A5, 13, 1'b1, rb);
        rd_check(3'd6, "R11 coincident end");
        check("R11 ports", port_vec(), exp_vec());
        check("R5 doe final", 64'(doe_err), 64'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog all requirements act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule